// File: doc/BRIEF.md
# Compare-Match PWM Timer Channel

This block is a single 16-bit timer channel driven by a small register interface with 16-bit accesses. A prescaler divides the system clock by 1, 4, 16 or 64. The counter advances on a chosen edge of the prescaled clock, and only while an external start-enable input is high. Four compare registers are checked against the counter on every count tick. Each match sets a status flag. Any one of the compare registers can be chosen as the counter-clear source.

The output pin is controlled by a 3-bit output-control field, which holds an initial level and a match action (keep, drive low, drive high or toggle). The action is applied when compare A matches. In PWM mode, the match on the clear source also puts the pin back to its initial level. So compare A sets the duty and the clear compare (normally B) sets the period. While the channel is stopped, writing the output-control field forces the pin to the new initial level at once. Software can therefore hold the pin at a fixed 0% or 100% level without running the counter.

Top module: `pwm_timer_chan`

## Requirements
- R1: After a synchronous active-high reset, every register reads 0 and the pin is low.
- R2: Registers sit at word index bus_addr[5:2]: 0 control (8 bits), 1 mode (2 bits), 2 output control (3 bits), 3 interrupt enable (4 bits), 4 status (4 bits), 5 counter, 6 to 9 compares A to D (16 bits each).
  - Unused bits read as 0.
  - Read data appears on bus_rdata one cycle after bus_rd is sampled and then holds until the next read.
  - Indices 10 to 15, and any access with bus_addr[1:0] not 0, read as 0 and write nothing.
- R3: Control bits 1:0 select the prescaler. Code 0 gives a tick on every cycle. Codes 1, 2 and 3 use bit 1, 3 or 5 of a free-running 6-bit prescale counter as the prescaled clock, which divides by 4, 16 or 64.
- R4: Control bits 4:3 select the counting edge of the prescaled clock: 0 is the rising transition, 1 is falling, and 2 or 3 is both. With prescaler code 0, every cycle is a tick regardless of the edge code.
- R5: While start_en is low, no tick occurs and both the prescale counter and the main counter hold their values.
- R6: Control bits 7:5 choose the clear source: 1 is compare A, 2 is B, 5 is C, 6 is D, and any other code means no clearing. On a tick where the counter equals the clear compare value N, the counter goes to 0 instead of N+1, so the period is N+1 ticks.
- R7: On a tick, status bit i (0 = A through 3 = D) is set when the counter equals compare i. Writing the status register clears each bit written as 0. A set in the same cycle wins over the clear.
- R8: In PWM mode (mode 2), on a tick where compare A matches, the match action is applied to the pin (0 keep, 1 low, 2 high, 3 toggle). If the clear compare also matches on that tick, the pin returns to the initial level (output control bit 2), and this return takes priority.
- R9: In any other mode the compare A action is applied, but a clear match does not restore the initial level.
- R10: A write to output control while start_en is low drives the pin to the written bit 2 on the next cycle. While the channel runs, the write only stores the new value, and the pin changes only on ticks.
- R11: Rewriting compare A while the channel runs changes the duty from the next tick on, without resetting or pausing the counter.
- R12: A write to the counter loads the written value and takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_en | input | 1 | Channel start enable from the shared start register |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pin_out | output | 1 | Timer output pin |

## Verification
A behavioural reference model is compared with the design on every cycle. In the main PWM tests the counter is read back continuously, so timing of the prescaler and the clear point is checked cycle by cycle.

The waveform tests run with every prescaler ratio and every edge code. These separate a wrong tap bit from a wrong edge polarity, and show whether a clear compare value of N gives N+1 ticks. Switching the clear source between A, B, C, D and the unmapped codes shows whether the decode picks the right register.

Further tests isolate specific behaviours:
- Start/stop gaps check that nothing moves while the channel is stopped.
- Toggle actions in normal mode check that the level is not restored at the clear point.
- Output-control writes while running and while stopped check the difference between storing the value and forcing the pin.

A final stretch of random register traffic mixes all of these.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

  typedef enum logic [3:0] {
    RI_CTRL = 4'd0,
    RI_MODE = 4'd1,
    RI_OUTC = 4'd2,
    RI_IEN  = 4'd3,
    RI_STAT = 4'd4,
    RI_CNT  = 4'd5,
    RI_CMPA = 4'd6
  } reg_idx_e;

  localparam logic [1:0] MODE_PWM = 2'd2;

  typedef enum logic [1:0] {ACT_KEEP, ACT_LOW, ACT_HIGH, ACT_TOGGLE} pin_act_e;
  typedef enum logic [1:0] {EDGE_RISE, EDGE_FALL, EDGE_BOTH, EDGE_BOTH2} edge_e;

  typedef struct packed {
    logic       en;
    logic [1:0] idx;
  } clr_sel_t;

  // Counter-clear source decode: A=1, B=2, C=5, D=6, others none
  function automatic clr_sel_t decode_clr(input logic [2:0] code);
    clr_sel_t s;
    case (code)
      3'd1:    s = '{en: 1'b1, idx: 2'd0};
      3'd2:    s = '{en: 1'b1, idx: 2'd1};
      3'd5:    s = '{en: 1'b1, idx: 2'd2};
      3'd6:    s = '{en: 1'b1, idx: 2'd3};
      default: s = '{en: 1'b0, idx: 2'd0};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int PRE_W = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] div_sel,
  input  logic [1:0] edge_sel,
  output logic       tick
);
  import pwm_chan_pkg::*;

  localparam int TAP_W = $clog2(PRE_W);

  logic [PRE_W-1:0] pre_q, pre_nx;
  logic [TAP_W-1:0] tap;
  logic             old_b, new_b;

  assign pre_nx = pre_q + 1'b1;

  always_comb begin
    case (div_sel)
      2'd1:    tap = TAP_W'(1);
      2'd2:    tap = TAP_W'(3);
      default: tap = TAP_W'(5);
    endcase
  end

  assign old_b = pre_q[tap];
  assign new_b = pre_nx[tap];

  always_comb begin
    if (!run)                tick = 1'b0;
    else if (div_sel == 2'd0) tick = 1'b1;
    else begin
      case (edge_e'(edge_sel))
        EDGE_RISE: tick = !old_b && new_b;
        EDGE_FALL: tick = old_b && !new_b;
        default:   tick = old_b ^ new_b;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      pre_q <= '0;
    else if (run) pre_q <= pre_nx;
  end

  AST_TICK_GATED: assert property (@(posedge clk) disable iff (rst)
    tick |-> run); // R5
  AST_PRE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(pre_q)); // R5

endmodule

// File: rtl/pwm_count_match.sv
module pwm_count_match #(
  parameter int CNT_W   = 16,
  parameter int NUM_CMP = 4,
  parameter int SEL_W   = $clog2(NUM_CMP)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tick,
  input  logic [NUM_CMP*CNT_W-1:0] cmp_flat,
  input  logic                     clr_en,
  input  logic [SEL_W-1:0]         clr_idx,
  input  logic                     cnt_wr,
  input  logic [CNT_W-1:0]         cnt_wdata,
  input  logic                     flag_wr,
  input  logic [NUM_CMP-1:0]       flag_wdata,
  output logic [CNT_W-1:0]         cnt,
  output logic [NUM_CMP-1:0]       flags,
  output logic [NUM_CMP-1:0]       hit,
  output logic                     clr_hit
);

  logic [CNT_W-1:0]   cnt_q;
  logic [NUM_CMP-1:0] flag_q;

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    assign hit[i] = (cnt_q == cmp_flat[i*CNT_W +: CNT_W]);

    always_ff @(posedge clk) begin
      if (rst)                             flag_q[i] <= 1'b0;
      else if (tick && hit[i])             flag_q[i] <= 1'b1;
      else if (flag_wr && !flag_wdata[i])  flag_q[i] <= 1'b0;
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
      (tick && hit[i]) |=> flag_q[i]); // R7
  end

  assign clr_hit = clr_en && hit[clr_idx];

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (cnt_wr) cnt_q <= cnt_wdata;
    else if (tick)   cnt_q <= clr_hit ? '0 : cnt_q + 1'b1;
  end

  assign cnt   = cnt_q;
  assign flags = flag_q;

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick && !cnt_wr) |=> $stable(cnt_q)); // R5
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (tick && clr_hit && !cnt_wr) |=> (cnt_q == '0)); // R6
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (cnt_q == $past(cnt_wdata))); // R12

endmodule

// File: rtl/pwm_pin_ctl.sv
module pwm_pin_ctl (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       run,
  input  logic       pwm_mode,
  input  logic       hit_a,
  input  logic       clr_hit,
  input  logic       init_lvl,
  input  logic [1:0] action,
  input  logic       outc_wr,
  input  logic       outc_wlvl,
  output logic       pin
);
  import pwm_chan_pkg::*;

  logic pin_q, pin_nx, force_lvl;

  assign force_lvl = outc_wr && !run;

  always_comb begin
    pin_nx = pin_q;
    if (hit_a) begin
      case (pin_act_e'(action))
        ACT_LOW:    pin_nx = 1'b0;
        ACT_HIGH:   pin_nx = 1'b1;
        ACT_TOGGLE: pin_nx = !pin_q;
        default:    pin_nx = pin_q;
      endcase
    end
    if (pwm_mode && clr_hit) pin_nx = init_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst)            pin_q <= 1'b0;
    else if (force_lvl) pin_q <= outc_wlvl;
    else if (tick)      pin_q <= pin_nx;
  end

  assign pin = pin_q;

  AST_PIN_FORCE: assert property (@(posedge clk) disable iff (rst)
    (outc_wr && !run) |=> (pin_q == $past(outc_wlvl))); // R10
  AST_PIN_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!tick && !(outc_wr && !run)) |=> $stable(pin_q)); // R10
  AST_PIN_RESTORE: assert property (@(posedge clk) disable iff (rst)
    (tick && pwm_mode && clr_hit) |=> (pin_q == $past(init_lvl))); // R8

endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan #(
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 16,
  parameter int NUM_CMP = 4,
  parameter int PRE_W   = 6,
  parameter int ADDR_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_en,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pin_out
);
  import pwm_chan_pkg::*;

  localparam int IDX_W = ADDR_W - 2;
  localparam int SEL_W = $clog2(NUM_CMP);

  logic [IDX_W-1:0]         ridx;
  logic                     aligned, wr_ok;
  logic [7:0]               ctrl_q;
  logic [1:0]               mode_q;
  logic [2:0]               outc_q;
  logic [NUM_CMP-1:0]       ien_q;
  logic [CNT_W-1:0]         cmp_q [NUM_CMP];
  logic [NUM_CMP*CNT_W-1:0] cmp_flat;
  logic [DATA_W-1:0]        rd_mux, rdata_q;
  logic                     tick, clr_hit, pin_w;
  logic [CNT_W-1:0]         cnt_w;
  logic [NUM_CMP-1:0]       flags_w, hit_w;
  clr_sel_t                 clr_sel;

  assign ridx    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_ok   = bus_wr && aligned;
  assign clr_sel = decode_clr(ctrl_q[7:5]);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      mode_q <= '0;
      outc_q <= '0;
      ien_q  <= '0;
    end else if (wr_ok) begin
      if (ridx == IDX_W'(RI_CTRL)) ctrl_q <= bus_wdata[7:0];
      if (ridx == IDX_W'(RI_MODE)) mode_q <= bus_wdata[1:0];
      if (ridx == IDX_W'(RI_OUTC)) outc_q <= bus_wdata[2:0];
      if (ridx == IDX_W'(RI_IEN))  ien_q  <= bus_wdata[NUM_CMP-1:0];
    end
  end

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmpreg
    always_ff @(posedge clk) begin
      if (rst) cmp_q[i] <= '0;
      else if (wr_ok && ridx == IDX_W'(int'(RI_CMPA) + i))
        cmp_q[i] <= bus_wdata[CNT_W-1:0];
    end
    assign cmp_flat[i*CNT_W +: CNT_W] = cmp_q[i];
  end

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      case (ridx)
        IDX_W'(RI_CTRL): rd_mux = DATA_W'(ctrl_q);
        IDX_W'(RI_MODE): rd_mux = DATA_W'(mode_q);
        IDX_W'(RI_OUTC): rd_mux = DATA_W'(outc_q);
        IDX_W'(RI_IEN):  rd_mux = DATA_W'(ien_q);
        IDX_W'(RI_STAT): rd_mux = DATA_W'(flags_w);
        IDX_W'(RI_CNT):  rd_mux = DATA_W'(cnt_w);
        default: begin
          for (int i = 0; i < NUM_CMP; i++)
            if (ridx == IDX_W'(int'(RI_CMPA) + i)) rd_mux = DATA_W'(cmp_q[i]);
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;

  pwm_tick_gen #(.PRE_W(PRE_W)) u_tick (
    .clk      (clk),
    .rst      (rst),
    .run      (start_en),
    .div_sel  (ctrl_q[1:0]),
    .edge_sel (ctrl_q[4:3]),
    .tick     (tick)
  );

  pwm_count_match #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP), .SEL_W(SEL_W)) u_count (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .cmp_flat   (cmp_flat),
    .clr_en     (clr_sel.en),
    .clr_idx    (SEL_W'(clr_sel.idx)),
    .cnt_wr     (wr_ok && ridx == IDX_W'(RI_CNT)),
    .cnt_wdata  (bus_wdata[CNT_W-1:0]),
    .flag_wr    (wr_ok && ridx == IDX_W'(RI_STAT)),
    .flag_wdata (bus_wdata[NUM_CMP-1:0]),
    .cnt        (cnt_w),
    .flags      (flags_w),
    .hit        (hit_w),
    .clr_hit    (clr_hit)
  );

  pwm_pin_ctl u_pin (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .run       (start_en),
    .pwm_mode  (mode_q == MODE_PWM),
    .hit_a     (hit_w[0]),
    .clr_hit   (clr_hit),
    .init_lvl  (outc_q[2]),
    .action    (outc_q[1:0]),
    .outc_wr   (wr_ok && ridx == IDX_W'(RI_OUTC)),
    .outc_wlvl (bus_wdata[2]),
    .pin       (pin_w)
  );

  assign pin_out = pin_w;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R2
  AST_STOP_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !start_en |-> !tick); // R5

endmodule

// File: tb/pwm_timer_chan_bench.sv
module pwm_timer_chan_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  wire  [15:0] bus_rdata;
  wire         pin_out;

  always #4 clk = ~clk;

  pwm_timer_chan u_pwm_timer_chan (
    .clk       (clk),
    .rst       (rst),
    .start_en  (start_en),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  string tag = "R1";
  bit    done = 1'b0;

  // reference model state
  int m_ctrl, m_mode, m_outc, m_ien, m_stat, m_cnt, m_pre, m_pin, m_rd;
  int m_cmp [4];

  always @(posedge clk) begin : ref_model
    int widx, rv, tk, k, nx, ob, nb, clr_en, clr_i, chit, p;
    int hits [4];
    bit wok;
    if (rst) begin
      m_ctrl = 0; m_mode = 0; m_outc = 0; m_ien = 0; m_stat = 0;
      m_cnt = 0; m_pre = 0; m_pin = 0; m_rd = 0;
      for (int i = 0; i < 4; i++) m_cmp[i] = 0;
    end else begin
      widx = int'(bus_addr) / 4;
      wok  = (bus_addr % 4) == 0;
      // read from old state
      rv = 0;
      if (wok) begin
        if (widx == 0) rv = m_ctrl;
        else if (widx == 1) rv = m_mode;
        else if (widx == 2) rv = m_outc;
        else if (widx == 3) rv = m_ien;
        else if (widx == 4) rv = m_stat;
        else if (widx == 5) rv = m_cnt;
        else if (widx >= 6 && widx <= 9) rv = m_cmp[widx-6];
      end
      if (bus_rd) m_rd = rv;
      // tick
      tk = 0;
      if (start_en) begin
        if ((m_ctrl & 3) == 0) tk = 1;
        else begin
          k  = 2 * (m_ctrl & 3) - 1;
          nx = (m_pre + 1) % 64;
          ob = (m_pre >> k) & 1;
          nb = (nx >> k) & 1;
          case ((m_ctrl >> 3) & 3)
            0: tk = (ob == 0 && nb == 1) ? 1 : 0;
            1: tk = (ob == 1 && nb == 0) ? 1 : 0;
            default: tk = (ob != nb) ? 1 : 0;
          endcase
        end
      end
      for (int i = 0; i < 4; i++) hits[i] = (m_cnt == m_cmp[i]) ? 1 : 0;
      clr_en = 1; clr_i = 0;
      case ((m_ctrl >> 5) & 7)
        1: clr_i = 0;
        2: clr_i = 1;
        5: clr_i = 2;
        6: clr_i = 3;
        default: clr_en = 0;
      endcase
      chit = clr_en ? hits[clr_i] : 0;
      // pin
      p = m_pin;
      if (bus_wr && wok && widx == 2 && !start_en) p = (bus_wdata >> 2) & 1;
      else if (tk != 0) begin
        if (hits[0] != 0) begin
          case (m_outc & 3)
            1: p = 0;
            2: p = 1;
            3: p = 1 - m_pin;
            default: p = m_pin;
          endcase
        end
        if (m_mode == 2 && chit != 0) p = (m_outc >> 2) & 1;
      end
      // status
      if (bus_wr && wok && widx == 4) m_stat = m_stat & int'(bus_wdata & 16'hF);
      if (tk != 0)
        for (int i = 0; i < 4; i++) if (hits[i] != 0) m_stat = m_stat | (1 << i);
      // counter
      if (bus_wr && wok && widx == 5) m_cnt = int'(bus_wdata);
      else if (tk != 0) m_cnt = (chit != 0) ? 0 : (m_cnt + 1) % 65536;
      if (start_en) m_pre = (m_pre + 1) % 64;
      m_pin = p;
      if (bus_wr && wok) begin
        if (widx == 0) m_ctrl = int'(bus_wdata & 16'hFF);
        if (widx == 1) m_mode = int'(bus_wdata & 16'h3);
        if (widx == 2) m_outc = int'(bus_wdata & 16'h7);
        if (widx == 3) m_ien  = int'(bus_wdata & 16'hF);
        if (widx >= 6 && widx <= 9) m_cmp[widx-6] = int'(bus_wdata);
      end
    end
  end

  task automatic check(string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    check("pin", int'(pin_out), m_pin);
    check("rdata", int'(bus_rdata), m_rd);
  endtask

  task automatic wr(int idx, int data);
    bus_wr = 1'b1;
    bus_addr = 6'(idx * 4);
    bus_wdata = 16'(data);
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd_run(int idx, int n);
    bus_rd = 1'b1;
    bus_addr = 6'(idx * 4);
    repeat (n) step();
    bus_rd = 1'b0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R5 watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state
    tag = "R1";
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    for (int i = 0; i < 10; i++) rd_run(i, 2);

    // R2: readback widths, unmapped and misaligned accesses
    tag = "R2";
    for (int i = 0; i < 10; i++) begin
      if (i != 4 && i != 5) wr(i, 16'hFFFF - i);
      rd_run(i, 2);
    end
    rd_run(10, 2);
    rd_run(15, 2);
    bus_wr = 1'b1; bus_addr = 6'h19; bus_wdata = 16'h1234; step(); bus_wr = 1'b0;
    bus_rd = 1'b1; bus_addr = 6'h1A; step(); step(); bus_rd = 1'b0;
    rd_run(6, 2);
    wr(3, 0);

    // R8: PWM waveform, clear on B, init high, clear on A match
    tag = "R8";
    wr(0, (2 << 5));
    wr(1, 2);
    wr(2, 3'b101);
    wr(6, 3); wr(7, 9); wr(8, 100); wr(9, 200);
    wr(5, 0);
    wr(4, 0);
    start_en = 1'b1;
    rd_run(5, 45);
    // R3: prescaler ratios
    tag = "R3";
    wr(0, (2 << 5) | 1); rd_run(5, 90);
    wr(0, (2 << 5) | 2); rd_run(5, 250);
    wr(0, (2 << 5) | 3); rd_run(5, 900);
    // R4: edge select
    tag = "R4";
    wr(0, (2 << 5) | (1 << 3) | 1); rd_run(5, 60);
    wr(0, (2 << 5) | (2 << 3) | 1); rd_run(5, 60);
    wr(0, (2 << 5) | (3 << 3) | 2); rd_run(5, 80);
    wr(0, (2 << 5) | (2 << 3));     rd_run(5, 20);
    // R5: stop holds counter and prescaler
    tag = "R5";
    wr(0, (2 << 5) | 1);
    rd_run(5, 7);
    start_en = 1'b0; rd_run(5, 25);
    start_en = 1'b1; rd_run(5, 40);
    // R6: clear source selection
    tag = "R6";
    wr(6, 2); wr(8, 5); wr(9, 7);
    wr(0, (5 << 5)); rd_run(5, 30);
    wr(0, (6 << 5)); rd_run(5, 30);
    wr(0, (1 << 5)); rd_run(5, 20);
    wr(0, (3 << 5)); rd_run(5, 30);
    wr(0, (0 << 5)); rd_run(5, 20);
    // R7: status flags
    tag = "R7";
    wr(5, 0); wr(0, (6 << 5));
    rd_run(4, 20);
    wr(4, 16'hE); rd_run(4, 3);
    start_en = 1'b0;
    wr(4, 0); rd_run(4, 3);
    start_en = 1'b1; rd_run(4, 12);
    // R9: normal mode, toggle action, no restore
    tag = "R9";
    wr(1, 0); wr(2, 3'b011); wr(0, (2 << 5)); wr(6, 3); wr(7, 9);
    rd_run(5, 60);
    // R10: forced level when stopped, stored only when running
    tag = "R10";
    start_en = 1'b0;
    wr(2, 3'b100); rd_run(2, 3);
    wr(2, 3'b001); rd_run(2, 3);
    wr(2, 3'b110); rd_run(2, 3);
    start_en = 1'b1;
    wr(1, 2);
    wr(2, 3'b001); rd_run(5, 30);
    // R11: duty change while running
    tag = "R11";
    wr(2, 3'b101);
    rd_run(5, 23);
    wr(6, 6); rd_run(5, 30);
    wr(6, 1); rd_run(5, 30);
    // R12: counter load
    tag = "R12";
    wr(5, 4); rd_run(5, 12);
    wr(5, 300); rd_run(5, 6);
    wr(5, 8); rd_run(5, 12);
    // mixed random traffic
    tag = "R8";
    for (int n = 0; n < 1500; n++) begin
      int c;
      c = int'($urandom_range(0, 99));
      if (c < 8) begin
        int idx;
        idx = int'($urandom_range(0, 9));
        if (idx == 0) wr(0, int'($urandom_range(0, 255)));
        else if (idx >= 6 || idx == 5) wr(idx, int'($urandom_range(0, 15)));
        else wr(idx, int'($urandom_range(0, 65535)));
      end else if (c < 11) begin
        start_en = ~start_en;
        step();
      end else begin
        rd_run(int'($urandom_range(0, 11)), 1);
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule